// File: doc/BRIEF.md
# PTP Timestamp Latency Compensator

This block corrects raw transmit and receive Precision Time Protocol timestamps by a signed extra latency that software programs, one value per direction. A timestamp is 48 bits wide: the upper 32 bits count whole nanoseconds and the lower 16 bits count 1/65536 ns. The latency word is sign-magnitude. Its magnitude is added to the timestamp, or subtracted from it, with carry and borrow across the fraction boundary. All arithmetic wraps modulo 2^48.

On the transmit side the corrected value is always reported for two-step use. When the one-step flag is set, the block also formats the bytes to insert: a timestamp field, an extension field and a correction field. A debug control replaces those inserted bytes with fixed fill patterns so that insertion can be seen on the wire. A small register port holds the two latency words, the debug control and the datapath clock period.

Top module: `ptp_latency_comp`

## Requirements
- R1: A latency word with bit 31 = 0 adds its magnitude to the timestamp. The magnitude is bits 30:16 in ns and bits 15:0 in 1/65536 ns, so +2.5 ns is 32'h00028000 and +5 ns is 32'h00050000. A fraction overflow carries into the ns bits, and the result wraps modulo 2^48.
- R2: A latency word with bit 31 = 1 subtracts the magnitude. A fraction underflow borrows from the ns bits, and a result below zero wraps modulo 2^48.
- R3: The transmit latency (address 0) corrects only the transmit path, and the receive latency (address 1) corrects only the receive path. Both reset to zero, and both read back as written.
- R4: A timestamp sampled with its valid on a rising edge is presented on the corrected output, with its own valid, after the second following rising edge. The output valid is the input valid delayed by two cycles.
- R5: A register write applies to every timestamp sampled on a rising edge later than the write's edge. A timestamp sampled on the same edge as the write still uses the old value.
- R6: The transmit correction is applied to the reported timestamp whether the one-step flag is set or clear.
- R7: For a one-step transmit timestamp, the timestamp field (32 bits) equals corrected bits 47:16, and the extension field (16 bits) equals corrected bits 15:0. The correction field (64 bits) is the signed latency in two's complement, in units of 1/65536 ns. For a two-step timestamp all three fields are zero.
- R8: With debug bit 0 (address 2) set, a one-step timestamp gets 8'hAA in every timestamp-field byte, 8'hBB in every correction-field byte and 8'hCC in every extension-field byte. The reported corrected timestamp is unchanged.
- R9: The debug register reads back with bits 31:1 zero, whatever value was written.
- R10: The clock period register (address 3) holds 20 bits: 4 bits of ns and 16 bits of fraction. It resets to 20'h27B81, and bits 31:20 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register write address |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_addr | input | 2 | Register read address |
| cfg_rd_data | output | 32 | Register read data, combinational |
| tx_in_vld | input | 1 | Raw transmit timestamp valid |
| tx_in_onestep | input | 1 | Transmit timestamp is for one-step insertion |
| tx_in_ts | input | 48 | Raw transmit timestamp |
| rx_in_vld | input | 1 | Raw receive timestamp valid |
| rx_in_ts | input | 48 | Raw receive timestamp |
| tx_out_vld | output | 1 | Corrected transmit timestamp valid |
| tx_out_ts | output | 48 | Corrected transmit timestamp |
| tx_ins_ts | output | 32 | One-step timestamp field bytes |
| tx_ins_ext | output | 16 | One-step extension field bytes |
| tx_ins_corr | output | 64 | One-step correction field bytes |
| rx_out_vld | output | 1 | Corrected receive timestamp valid |
| rx_out_ts | output | 48 | Corrected receive timestamp |

## Verification
Each corrected timestamp and its insertion fields are due after the second rising edge following the edge that samples the input valid. The bench drives stimulus on falling edges. It checks that the output valid is still low one falling edge later, and it compares values exactly one cycle after that. Register reads are combinational and are checked within the same cycle. Write ordering is tested by writing on the same edge that samples a timestamp, and again one edge before one.

// File: rtl/ptp_lat_pkg.sv
package ptp_lat_pkg;
    localparam int TS_W    = 48;
    localparam int FRAC_W  = 16;
    localparam int LAT_W   = 32;
    localparam int MAG_W   = LAT_W - 1;
    localparam int CORR_W  = 64;
    localparam int PER_W   = 20;
    localparam int REG_AW  = 2;
    localparam int INS_TS_W = TS_W - FRAC_W;

    localparam logic [PER_W-1:0]  PERIOD_RST = 20'h27B81;
    localparam logic [REG_AW-1:0] A_TXLAT  = 2'd0;
    localparam logic [REG_AW-1:0] A_RXLAT  = 2'd1;
    localparam logic [REG_AW-1:0] A_DBG    = 2'd2;
    localparam logic [REG_AW-1:0] A_PERIOD = 2'd3;

    localparam logic [7:0] FILL_TS   = 8'hAA;
    localparam logic [7:0] FILL_CORR = 8'hBB;
    localparam logic [7:0] FILL_EXT  = 8'hCC;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } lat_t;

    typedef struct packed {
        logic            vld;
        logic            one;
        logic            dbg;
        lat_t            lat;
        logic [TS_W-1:0] ts;
    } stamp_t;

    typedef struct packed {
        logic [INS_TS_W-1:0] ts;
        logic [FRAC_W-1:0]   ext;
        logic [CORR_W-1:0]   corr;
    } ins_t;

    function automatic lat_t decode_lat(input logic [LAT_W-1:0] w);
        lat_t l;
        l.neg = w[LAT_W-1];
        l.mag = w[MAG_W-1:0];
        return l;
    endfunction

    function automatic logic [TS_W-1:0] shift_ts(input logic [TS_W-1:0] ts, input lat_t l);
        logic [TS_W-1:0] ext;
        ext = {{(TS_W-MAG_W){1'b0}}, l.mag};
        return l.neg ? (ts - ext) : (ts + ext);
    endfunction

    function automatic logic [CORR_W-1:0] corr_of(input lat_t l);
        logic [CORR_W-1:0] m;
        m = {{(CORR_W-MAG_W){1'b0}}, l.mag};
        return l.neg ? (~m + 1'b1) : m;
    endfunction
endpackage

// File: rtl/ptp_lat_regs.sv
module ptp_lat_regs
    import ptp_lat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [LAT_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [LAT_W-1:0]  rd_data,
    output lat_t              tx_lat,
    output lat_t              rx_lat,
    output logic              dbg_fill
);
    logic [LAT_W-1:0] tx_word_q, rx_word_q;
    logic             dbg_q;
    logic [PER_W-1:0] period_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_word_q <= '0;
            rx_word_q <= '0;
            dbg_q     <= 1'b0;
            period_q  <= PERIOD_RST;
        end else if (wr_en) begin
            case (wr_addr)
                A_TXLAT:  tx_word_q <= wr_data;
                A_RXLAT:  rx_word_q <= wr_data;
                A_DBG:    dbg_q     <= wr_data[0];
                default:  period_q  <= wr_data[PER_W-1:0];
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_TXLAT: rd_data = tx_word_q;
            A_RXLAT: rd_data = rx_word_q;
            A_DBG:   rd_data = {{(LAT_W-1){1'b0}}, dbg_q};
            default: rd_data = {{(LAT_W-PER_W){1'b0}}, period_q};
        endcase
    end

    assign tx_lat   = decode_lat(tx_word_q);
    assign rx_lat   = decode_lat(rx_word_q);
    assign dbg_fill = dbg_q;

    AST_RESET_VALUES: assert property (@(posedge clk) $past(rst) |-> (tx_word_q == '0 && rx_word_q == '0 && period_q == PERIOD_RST)); // R3
    AST_PERIOD_HOLDS: assert property (@(posedge clk) disable iff (rst) !$past(wr_en) |-> $stable(period_q)); // R10
endmodule

// File: rtl/ptp_lat_path.sv
module ptp_lat_path
    import ptp_lat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic            in_one,
    input  logic            in_dbg,
    input  lat_t            in_lat,
    input  logic [TS_W-1:0] in_ts,
    output stamp_t          out_q
);
    stamp_t s1_q;

    // stage 1: capture raw stamp with the latency in force at this edge
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld <= in_vld;
            s1_q.one <= in_one & in_vld;
            s1_q.dbg <= in_dbg;
            s1_q.lat <= in_lat;
            s1_q.ts  <= in_ts;
        end
    end

    // stage 2: signed adjust
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q     <= s1_q;
            out_q.ts  <= shift_ts(s1_q.ts, s1_q.lat);
        end
    end

    AST_TWO_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst) out_q.vld == $past(in_vld, 2)); // R4
    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst) (s1_q.vld && s1_q.lat.mag == '0) |=> (out_q.ts == $past(s1_q.ts))); // R1
    AST_ONE_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst) out_q.one |-> out_q.vld); // R7
endmodule

// File: rtl/ptp_onestep_fmt.sv
module ptp_onestep_fmt
    import ptp_lat_pkg::*;
(
    input  stamp_t st,
    output ins_t   ins
);
    localparam int TS_BYTES   = INS_TS_W / 8;
    localparam int EXT_BYTES  = FRAC_W / 8;
    localparam int CORR_BYTES = CORR_W / 8;

    ins_t fill;

    generate
        for (genvar b = 0; b < TS_BYTES; b++) begin : g_ts_fill
            assign fill.ts[b*8 +: 8] = FILL_TS;
        end
        for (genvar b = 0; b < EXT_BYTES; b++) begin : g_ext_fill
            assign fill.ext[b*8 +: 8] = FILL_EXT;
        end
        for (genvar b = 0; b < CORR_BYTES; b++) begin : g_corr_fill
            assign fill.corr[b*8 +: 8] = FILL_CORR;
        end
    endgenerate

    always_comb begin
        if (!st.one) begin
            ins = '0;
        end else if (st.dbg) begin
            ins = fill;
        end else begin
            ins.ts   = st.ts[TS_W-1:FRAC_W];
            ins.ext  = st.ts[FRAC_W-1:0];
            ins.corr = corr_of(st.lat);
        end
    end
endmodule

// File: rtl/ptp_latency_comp.sv
module ptp_latency_comp
    import ptp_lat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr_en,
    input  logic [1:0]  cfg_wr_addr,
    input  logic [31:0] cfg_wr_data,
    input  logic [1:0]  cfg_rd_addr,
    output logic [31:0] cfg_rd_data,
    input  logic        tx_in_vld,
    input  logic        tx_in_onestep,
    input  logic [47:0] tx_in_ts,
    input  logic        rx_in_vld,
    input  logic [47:0] rx_in_ts,
    output logic        tx_out_vld,
    output logic [47:0] tx_out_ts,
    output logic [31:0] tx_ins_ts,
    output logic [15:0] tx_ins_ext,
    output logic [63:0] tx_ins_corr,
    output logic        rx_out_vld,
    output logic [47:0] rx_out_ts
);
    lat_t   tx_lat, rx_lat;
    logic   dbg_fill;
    stamp_t tx_st, rx_st;
    ins_t   tx_ins;

    ptp_lat_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data),
        .tx_lat(tx_lat), .rx_lat(rx_lat), .dbg_fill(dbg_fill)
    );

    ptp_lat_path u_tx_path (
        .clk(clk), .rst(rst),
        .in_vld(tx_in_vld), .in_one(tx_in_onestep), .in_dbg(dbg_fill),
        .in_lat(tx_lat), .in_ts(tx_in_ts), .out_q(tx_st)
    );

    ptp_lat_path u_rx_path (
        .clk(clk), .rst(rst),
        .in_vld(rx_in_vld), .in_one(1'b0), .in_dbg(1'b0),
        .in_lat(rx_lat), .in_ts(rx_in_ts), .out_q(rx_st)
    );

    ptp_onestep_fmt u_fmt (.st(tx_st), .ins(tx_ins));

    assign tx_out_vld  = tx_st.vld;
    assign tx_out_ts   = tx_st.ts;
    assign tx_ins_ts   = tx_ins.ts;
    assign tx_ins_ext  = tx_ins.ext;
    assign tx_ins_corr = tx_ins.corr;
    assign rx_out_vld  = rx_st.vld;
    assign rx_out_ts   = rx_st.ts;

    AST_DEBUG_FILL: assert property (@(posedge clk) disable iff (rst)
        ($past(dbg_fill, 2) && $past(tx_in_vld && tx_in_onestep, 2)) |->
        (tx_ins_ts == 32'hAAAA_AAAA && tx_ins_ext == 16'hCCCC && tx_ins_corr == 64'hBBBB_BBBB_BBBB_BBBB)); // R8
    AST_TWO_STEP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_in_vld, 2) && !$past(tx_in_onestep, 2)) |->
        (tx_ins_ts == '0 && tx_ins_ext == '0 && tx_ins_corr == '0)); // R7
    AST_RX_VALID_DELAY: assert property (@(posedge clk) disable iff (rst) rx_out_vld == $past(rx_in_vld, 2)); // R4
endmodule

// File: tb/ptp_latency_comp_tb_top.sv
module ptp_latency_comp_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  cfg_rd_addr = '0;
    logic [31:0] cfg_rd_data;
    logic        tx_in_vld = 1'b0, tx_in_onestep = 1'b0, rx_in_vld = 1'b0;
    logic [47:0] tx_in_ts = '0, rx_in_ts = '0;
    logic        tx_out_vld, rx_out_vld;
    logic [47:0] tx_out_ts, rx_out_ts;
    logic [31:0] tx_ins_ts;
    logic [15:0] tx_ins_ext;
    logic [63:0] tx_ins_corr;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptp_latency_comp dut_i (.*);

    logic [31:0] lats [8] = '{32'h0, 32'h0002_8000, 32'h0005_0000, 32'h8000_0001,
                              32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_FFFF};
    logic [47:0] stamps [8] = '{48'h0, 48'h0000_0000_FFFF, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABC,
                                48'h0000_0001_0000, 48'h8000_0000_8000, 48'hFFFF_FFFF_0000, 48'h0000_7FFF_8001};

    function automatic logic [47:0] exp_ts(input logic [47:0] ts, input logic [31:0] lat);
        logic [47:0] m = {17'b0, lat[30:0]};
        return lat[31] ? ts - m : ts + m;
    endfunction

    function automatic logic [63:0] exp_corr(input logic [31:0] lat);
        logic [63:0] m = {33'b0, lat[30:0]};
        return lat[31] ? 64'(0) - m : m;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        cfg_rd_addr = a;
        #1;
        check(req, 128'(cfg_rd_data), 128'(exp));
    endtask

    // drive at a falling edge; result due after the second rising edge
    task automatic apply(input logic [47:0] tts, input logic [47:0] rts, input logic one,
                         input logic [31:0] tlat, input logic [31:0] rlat, input logic dbg,
                         input string tag);
        @(negedge clk);
        tx_in_vld = 1'b1; tx_in_ts = tts; tx_in_onestep = one;
        rx_in_vld = 1'b1; rx_in_ts = rts;
        @(negedge clk);
        tx_in_vld = 1'b0; rx_in_vld = 1'b0;
        check({tag, " R4 early"}, 128'(tx_out_vld), 128'(0));
        @(negedge clk);
        check({tag, " R4 tx valid"}, 128'(tx_out_vld), 128'(1));
        check({tag, " R4 rx valid"}, 128'(rx_out_vld), 128'(1));
        check({tag, " R1/R2/R6 tx ts"}, 128'(tx_out_ts), 128'(exp_ts(tts, tlat)));
        check({tag, " R3 rx ts"}, 128'(rx_out_ts), 128'(exp_ts(rts, rlat)));
        if (!one) begin
            check({tag, " R7 two-step fields"}, {tx_ins_ts, tx_ins_ext, tx_ins_corr}, 128'(0));
        end else if (dbg) begin
            check({tag, " R8 fill"}, {tx_ins_ts, tx_ins_ext, tx_ins_corr},
                  {32'hAAAA_AAAA, 16'hCCCC, 64'hBBBB_BBBB_BBBB_BBBB});
        end else begin
            logic [47:0] e = exp_ts(tts, tlat);
            check({tag, " R7 fields"}, {tx_ins_ts, tx_ins_ext, tx_ins_corr},
                  {e[47:16], e[15:0], exp_corr(tlat)});
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // reset state
        check("R4 reset tx valid", 128'(tx_out_vld), 128'(0));
        check("R4 reset rx valid", 128'(rx_out_vld), 128'(0));
        rd_chk(2'd0, 32'h0, "R3 tx reset");
        rd_chk(2'd1, 32'h0, "R3 rx reset");
        rd_chk(2'd2, 32'h0, "R9 dbg reset");
        rd_chk(2'd3, 32'h0002_7B81, "R10 period reset");

        // near-exhaustive sweep
        for (int d = 0; d < 2; d++) begin
            wr(2'd2, d[0] ? 32'hFFFF_FFFF : 32'h0);
            rd_chk(2'd2, {31'b0, d[0]}, "R9 dbg readback");
            for (int li = 0; li < 8; li++) begin
                wr(2'd0, lats[li]);
                wr(2'd1, lats[(li + 3) % 8]);
                rd_chk(2'd0, lats[li], "R3 tx readback");
                rd_chk(2'd1, lats[(li + 3) % 8], "R3 rx readback");
                for (int ti = 0; ti < 8; ti++) begin
                    for (int o = 0; o < 2; o++) begin
                        apply(stamps[ti], stamps[7 - ti], o[0], lats[li], lats[(li + 3) % 8],
                              d[0], "sweep");
                    end
                end
            end
        end

        // R5: write on the same edge as a sampled stamp uses the old value
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h0002_8000);
        wr(2'd1, 32'h0);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = 2'd0; cfg_wr_data = 32'h8005_0000;
        tx_in_vld = 1'b1; tx_in_ts = 48'h0000_0010_0000; tx_in_onestep = 1'b0;
        @(negedge clk);
        cfg_wr_en = 1'b0; tx_in_vld = 1'b0;
        @(negedge clk);
        check("R5 same-edge old value", 128'(tx_out_ts), 128'(48'h0000_0012_8000));
        apply(48'h0000_0010_0000, 48'h5, 1'b1, 32'h8005_0000, 32'h0, 1'b0, "R5 next-edge new value");

        // R10 period width
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'h000F_FFFF, "R10 period width");
        rd_chk(2'd0, 32'h8005_0000, "R10 period write leaves tx latency");

        done = 1'b1;
        finish_run();
    end
endmodule